// File: doc/BRIEF.md
# Contact Smart Card Power-Up Sequencer

This block brings a contact smart card from an unpowered socket to the point where the card has left reset. It runs in a single clock domain, the internal oscillator clock. First it waits until the digital supply has been steady for a programmable settling time, and only then raises its host interrupt line. After that, a host write that sets the start bit begins a timed ramp. The card supply is switched on first. After the first phase the I/O line turns to reception mode. A short second phase later the card clock starts. The card reset is released once a programmable number of card clock periods has elapsed.

The card supply must be reported good at the moment the first phase ends, or the session is dropped. A host write that clears the start bit while the ramp is still running also drops it. A dropped session returns every card pin to its inactive level, pulls the interrupt line low for one cycle and sets a sticky fault bit in the status word.

The card clock runs at the oscillator rate divided by a parameter. The reset delay is counted from a strobe that marks the end of each card clock period. The default settings match a 1.5 MHz oscillator, with a 10 ms settling time, a 765-cycle first phase, a 2-cycle second phase and 42001 card clock periods before reset release.

Top module: `card_activator`

## Requirements
- R1: After reset every card pin and `irq_line` are low. `irq_line` stays low while `vdd_ok` is low. It goes high on the (VDD_TICKS+1)-th rising edge after the first edge that samples `vdd_ok` high, provided `vdd_ok` stays high.
- R2: Whenever `vdd_ok` is sampled low, all card pins and `irq_line` are low from the next cycle on, and no fault is recorded. A later rise of `vdd_ok` restarts the settling wait.
- R3: A start request is a write with `ctrl_wdata[0]`=1. It is accepted only while the sequencer is ready (settled and idle) and `card_present` is 1. In any other case it has no effect and is not remembered.
- R4: `vcc_en` rises one cycle after an accepted start. `io_rx` rises exactly T1_TICKS cycles after `vcc_en`.
- R5: If `vcc_ok` is low at the clock edge that ends the first phase (the T1_TICKS-th edge after `vcc_en` rose), the session aborts. In the next cycle all card pins are low and `irq_line` is low. One cycle later `irq_line` is high again and a new start may be accepted.
- R6: `card_clk` first rises exactly T2_TICKS cycles after `io_rx`. From then on it has a period of CCLK_DIV cycles and is high for the first CCLK_DIV/2 cycles of each period.
- R7: `card_rst` rises exactly T3_CCLKS*CCLK_DIV cycles after the first rise of `card_clk`.
- R8: A write with `ctrl_wdata[0]`=0 while `vcc_en` is high and `card_rst` is still low aborts the session, with the same pin and interrupt behaviour as R5.
- R9: The fault bit `status[3]` is set on every abort. It remains set until a write with `ctrl_wdata[1]`=1, after which it reads 0 in the next cycle. If a set and a clear arrive in the same cycle, the set wins.
- R10: `status[0]` follows `card_present`, `status[1]` follows `vcc_ok`, and `status[2]` is 1 exactly while `card_rst` is high.
- R11: A write with `ctrl_wdata[0]`=0 after `card_rst` has risen drops all card pins low in the next cycle. `irq_line` stays high and `status[3]` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_ok | input | 1 | Digital supply within range |
| card_present | input | 1 | Debounced card detect |
| vcc_ok | input | 1 | Card supply reported valid |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 2 | Bit 0 start/stop, bit 1 fault clear |
| status | output | 4 | {fault, session up, supply valid, card present} |
| irq_line | output | 1 | Host interrupt: high when settled, low pulse on abort |
| vcc_en | output | 1 | Card supply enable |
| io_rx | output | 1 | 1 = card I/O in reception mode (pulled high), 0 = driven low |
| card_clk | output | 1 | Gated, divided card clock |
| card_rst | output | 1 | Card reset line, high = released |

## Verification
A corrupted phase counter or state register appears at the pins within the phase it disturbs. The bench therefore compares all five card and interrupt outputs on every cycle of every ramp against the cycle counts in R4, R6 and R7. Any edge that lands early or late is reported within one oscillator cycle of that edge. A wrong fault path shows within two cycles of the end of the first phase, in `irq_line` and `status[3]`. Starts in the wrong state, and glitches on the supply-valid input that recover before the phase ends, are both shown to leave every pin unchanged.

// File: rtl/card_act_pkg.sv
package card_act_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WAIT_VDD,
      S_READY,
      S_PWR_UP,
      S_IO_RX,
      S_CLK_ON,
      S_RST_WAIT,
      S_ACTIVE,
      S_ABORT
   } seq_state_e;

   localparam int CTL_W     = 2;
   localparam int CTL_START = 0;
   localparam int CTL_CLR   = 1;

   localparam int STAT_W       = 4;
   localparam int STAT_PRESENT = 0;
   localparam int STAT_VCC     = 1;
   localparam int STAT_UP      = 2;
   localparam int STAT_FAULT   = 3;

endpackage

// File: rtl/card_act_count.sv
module card_act_count #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [WIDTH-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/card_act_cclk.sv
module card_act_cclk #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   output logic card_clk,
   output logic strobe
);

   generate
      if (DIV == 2) begin : g_toggle
         logic phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= 1'b0;
            end else if (!gate) begin
               phase_q <= 1'b0;
            end else begin
               phase_q <= ~phase_q;
            end
         end

         assign card_clk = gate & ~phase_q;
         assign strobe   = gate & phase_q;
      end else begin : g_counter
         localparam int DW = $clog2(DIV);
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);
         localparam logic [DW-1:0] HALF = DW'(DIV / 2);
         logic [DW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!gate || div_q == LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end

         assign card_clk = gate & (div_q < HALF);
         assign strobe   = gate & (div_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
   import card_act_pkg::*;
#(
   parameter int VDD_TICKS = 15000,
   parameter int T1_TICKS  = 765,
   parameter int T2_TICKS  = 2,
   parameter int T3_CCLKS  = 42001,
   parameter int TW        = 14,
   parameter int CW        = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vdd_ok,
   input  logic          card_present,
   input  logic          vcc_ok,
   input  logic          start_wr,
   input  logic          stop_wr,
   input  logic [TW-1:0] tick_cnt,
   input  logic [CW-1:0] cclk_cnt,
   input  logic          cclk_strobe,
   output seq_state_e    state,
   output logic          tick_clr,
   output logic          tick_en,
   output logic          cclk_clr,
   output logic          abort_set
);

   localparam logic [TW-1:0] VDD_END = TW'(VDD_TICKS - 1);
   localparam logic [TW-1:0] T1_END  = TW'(T1_TICKS - 1);
   localparam logic [TW-1:0] T2_END  = TW'(T2_TICKS - 1);
   localparam logic [CW-1:0] T3_END  = CW'(T3_CCLKS - 1);

   seq_state_e nxt;
   logic       t3_done;

   assign t3_done = cclk_strobe && (cclk_cnt == T3_END);

   always_comb begin
      nxt = state;
      unique case (state)
         S_IDLE:     if (vdd_ok) nxt = S_WAIT_VDD;
         S_WAIT_VDD: if (tick_cnt == VDD_END) nxt = S_READY;
         S_READY:    if (start_wr && card_present) nxt = S_PWR_UP;
         S_PWR_UP: begin
            if (stop_wr) nxt = S_ABORT;
            else if (tick_cnt == T1_END) nxt = vcc_ok ? S_IO_RX : S_ABORT;
         end
         S_IO_RX: begin
            if (stop_wr) nxt = S_ABORT;
            else if (tick_cnt == T2_END) nxt = S_CLK_ON;
         end
         S_CLK_ON: begin
            if (stop_wr) nxt = S_ABORT;
            else if (t3_done) nxt = S_ACTIVE;
            else nxt = S_RST_WAIT;
         end
         S_RST_WAIT: begin
            if (stop_wr) nxt = S_ABORT;
            else if (t3_done) nxt = S_ACTIVE;
         end
         S_ACTIVE:   if (stop_wr) nxt = S_READY;
         S_ABORT:    nxt = S_READY;
         default:    nxt = S_IDLE;
      endcase
      if (!vdd_ok) nxt = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
      end else begin
         state <= nxt;
      end
   end

   assign tick_clr  = (nxt != state);
   assign tick_en   = (state == S_WAIT_VDD) || (state == S_PWR_UP) || (state == S_IO_RX);
   assign cclk_clr  = !((state == S_CLK_ON) || (state == S_RST_WAIT));
   assign abort_set = (nxt == S_ABORT);

endmodule

// File: rtl/card_activator.sv
module card_activator
   import card_act_pkg::*;
#(
   parameter int VDD_TICKS = 15000,
   parameter int T1_TICKS  = 765,
   parameter int T2_TICKS  = 2,
   parameter int T3_CCLKS  = 42001,
   parameter int CCLK_DIV  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vdd_ok,
   input  logic              card_present,
   input  logic              vcc_ok,
   input  logic              ctrl_wr,
   input  logic [CTL_W-1:0]  ctrl_wdata,
   output logic [STAT_W-1:0] status,
   output logic              irq_line,
   output logic              vcc_en,
   output logic              io_rx,
   output logic              card_clk,
   output logic              card_rst
);

   localparam int TICK_MAX = (VDD_TICKS > T1_TICKS)
                           ? ((VDD_TICKS > T2_TICKS) ? VDD_TICKS : T2_TICKS)
                           : ((T1_TICKS > T2_TICKS) ? T1_TICKS : T2_TICKS);
   localparam int TW = $clog2(TICK_MAX + 1);
   localparam int CW = $clog2(T3_CCLKS + 1);

   generate
      if (VDD_TICKS < 1) begin : g_bad_vdd
         $error("VDD_TICKS must be at least 1");
      end
      if (T1_TICKS < 1 || T2_TICKS < 1) begin : g_bad_phase
         $error("T1_TICKS and T2_TICKS must be at least 1");
      end
      if (T3_CCLKS < 2) begin : g_bad_t3
         $error("T3_CCLKS must be at least 2");
      end
      if (CCLK_DIV < 2) begin : g_bad_div
         $error("CCLK_DIV must be at least 2");
      end
   endgenerate

   seq_state_e    state;
   logic [TW-1:0] tick_cnt;
   logic [CW-1:0] cclk_cnt;
   logic          tick_clr, tick_en, cclk_clr, abort_set;
   logic          cclk_strobe, clk_gate;
   logic          start_wr, stop_wr;
   logic          fault_q;

   assign start_wr = ctrl_wr &  ctrl_wdata[CTL_START];
   assign stop_wr  = ctrl_wr & ~ctrl_wdata[CTL_START];

   card_act_seq #(
      .VDD_TICKS (VDD_TICKS),
      .T1_TICKS  (T1_TICKS),
      .T2_TICKS  (T2_TICKS),
      .T3_CCLKS  (T3_CCLKS),
      .TW        (TW),
      .CW        (CW)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .vdd_ok       (vdd_ok),
      .card_present (card_present),
      .vcc_ok       (vcc_ok),
      .start_wr     (start_wr),
      .stop_wr      (stop_wr),
      .tick_cnt     (tick_cnt),
      .cclk_cnt     (cclk_cnt),
      .cclk_strobe  (cclk_strobe),
      .state        (state),
      .tick_clr     (tick_clr),
      .tick_en      (tick_en),
      .cclk_clr     (cclk_clr),
      .abort_set    (abort_set)
   );

   card_act_count #(.WIDTH(TW)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tick_clr),
      .en    (tick_en),
      .cnt   (tick_cnt)
   );

   card_act_count #(.WIDTH(CW)) u_cclk_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cclk_clr),
      .en    (cclk_strobe),
      .cnt   (cclk_cnt)
   );

   assign clk_gate = (state == S_CLK_ON) || (state == S_RST_WAIT) || (state == S_ACTIVE);

   card_act_cclk #(.DIV(CCLK_DIV)) u_cclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (clk_gate),
      .card_clk (card_clk),
      .strobe   (cclk_strobe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else if (abort_set) begin
         fault_q <= 1'b1;
      end else if (ctrl_wr && ctrl_wdata[CTL_CLR]) begin
         fault_q <= 1'b0;
      end
   end

   assign vcc_en   = (state == S_PWR_UP) || (state == S_IO_RX) || clk_gate;
   assign io_rx    = (state == S_IO_RX) || clk_gate;
   assign card_rst = (state == S_ACTIVE);
   assign irq_line = !((state == S_IDLE) || (state == S_WAIT_VDD) || (state == S_ABORT));

   always_comb begin
      status               = '0;
      status[STAT_PRESENT] = card_present;
      status[STAT_VCC]     = vcc_ok;
      status[STAT_UP]      = card_rst;
      status[STAT_FAULT]   = fault_q;
   end

endmodule

// File: rtl/card_activator_chk.sv
module card_activator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vdd_ok,
   input logic       card_present,
   input logic       ctrl_wr,
   input logic [1:0] ctrl_wdata,
   input logic       fault,
   input logic       irq_line,
   input logic       vcc_en,
   input logic       io_rx,
   input logic       card_clk,
   input logic       card_rst
);

   p_io_needs_vcc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      io_rx |-> vcc_en);

   p_clk_needs_io_r6: assert property (@(posedge clk) disable iff (!rst_n)
      card_clk |-> io_rx);

   p_rst_needs_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst |-> (io_rx && vcc_en));

   p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vcc_en) |-> $past(ctrl_wr && ctrl_wdata[0] && card_present && irq_line));

   p_abort_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_line) && $past(vdd_ok)) |-> fault);

   p_abort_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_line) && $past(vdd_ok) && vdd_ok) |=> irq_line);

   p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !(ctrl_wr && ctrl_wdata[1])) |=> fault);

   p_vdd_loss_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(vdd_ok) |-> (!vcc_en && !irq_line && !card_clk && !card_rst));

endmodule

bind card_activator card_activator_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vdd_ok       (vdd_ok),
   .card_present (card_present),
   .ctrl_wr      (ctrl_wr),
   .ctrl_wdata   (ctrl_wdata),
   .fault        (status[3]),
   .irq_line     (irq_line),
   .vcc_en       (vcc_en),
   .io_rx        (io_rx),
   .card_clk     (card_clk),
   .card_rst     (card_rst)
);

// File: tb/card_activator_test.sv
module card_activator_test;

   localparam int VDD = 40;
   localparam int T1  = 765;
   localparam int T2  = 2;
   localparam int T3  = 300;
   localparam int DIV = 4;
   localparam int KC  = T1 + T2 + 1;
   localparam int KR  = KC + T3 * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vdd_ok = 1'b0;
   logic       card_present = 1'b1;
   logic       vcc_ok = 1'b1;
   logic       ctrl_wr = 1'b0;
   logic [1:0] ctrl_wdata = 2'b00;
   logic [3:0] status;
   logic       irq_line, vcc_en, io_rx, card_clk, card_rst;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   card_activator #(
      .VDD_TICKS (VDD),
      .T1_TICKS  (T1),
      .T2_TICKS  (T2),
      .T3_CCLKS  (T3),
      .CCLK_DIV  (DIV)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .vdd_ok       (vdd_ok),
      .card_present (card_present),
      .vcc_ok       (vcc_ok),
      .ctrl_wr      (ctrl_wr),
      .ctrl_wdata   (ctrl_wdata),
      .status       (status),
      .irq_line     (irq_line),
      .vcc_en       (vcc_en),
      .io_rx        (io_rx),
      .card_clk     (card_clk),
      .card_rst     (card_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [4:0] pins();
      return {vcc_en, io_rx, card_clk, card_rst, irq_line};
   endfunction

   // expected {vcc_en, io_rx, card_clk, card_rst, irq_line} k edges after an accepted start
   function automatic logic [4:0] exp_pins(int k, int ab, bit vdd_loss);
      logic v, i, c, r;
      if (ab > 0 && k >= ab) return {4'b0000, (!vdd_loss && k != ab)};
      v = (k >= 1);
      i = (k >= T1 + 1);
      c = (k >= KC) && (((k - KC) % DIV) < DIV / 2);
      r = (k >= KR);
      return {v, i, c, r, 1'b1};
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic host_write(input logic [1:0] d);
      ctrl_wr = 1'b1;
      ctrl_wdata = d;
      tick();
      ctrl_wr = 1'b0;
      ctrl_wdata = 2'b00;
   endtask

   // R1: settling wait, with an early start that must not be remembered (R3)
   task automatic power_up();
      vdd_ok = 1'b1;
      for (int n = 1; n <= VDD + 2; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (n == 3) begin
            ctrl_wr = 1'b0;
            ctrl_wdata = 2'b00;
         end
         chk("R1 irq after settling", irq_line, (n >= VDD + 1));
         chk("R3 start while settling ignored", vcc_en, 1'b0);
         if (n == 2) begin
            ctrl_wr = 1'b1;
            ctrl_wdata = 2'b01;
         end
      end
   endtask

   // mode 0 normal, 1 supply fault at end of t1, 2 host stop, 3 supply glitch, 4 vdd loss
   task automatic run_seq(input int mode, input int kev);
      int ab;
      int kend;
      bit pend;
      ab = -1;
      pend = 0;
      if (mode == 1) ab = T1 + 1;
      if (mode == 2 || mode == 4) ab = kev + 1;
      kend = (ab > 0) ? ab + 2 : KR + 2 * DIV;
      ctrl_wr = 1'b1;
      ctrl_wdata = 2'b01;
      for (int k = 1; k <= kend; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (pend) begin
            ctrl_wr = 1'b0;
            ctrl_wdata = 2'b00;
            pend = 0;
         end
         if (k == 1) begin
            ctrl_wr = 1'b0;
            ctrl_wdata = 2'b00;
         end
         if (mode == 1) chk("R5 pins vs t1 check", pins(), exp_pins(k, ab, 0));
         else if (mode == 2) chk("R8 pins vs host stop", pins(), exp_pins(k, ab, 0));
         else if (mode == 4) chk("R2 pins vs vdd loss", pins(), exp_pins(k, ab, 1));
         else chk("R4 R6 R7 ramp timing", pins(), exp_pins(k, ab, 0));
         if (k == ab && (mode == 1 || mode == 2)) chk("R9 fault set on abort", status[3], 1'b1);
         if (k == ab && mode == 4) chk("R2 no fault on vdd loss", status[3], 1'b0);
         if (k == KR && ab < 0) chk("R10 status up", status[2], 1'b1);
         if (k == KR - 1 && ab < 0) chk("R10 status up low before reset", status[2], 1'b0);
         if (mode == 1 && k == kev) vcc_ok = 1'b0;
         if (mode == 1 && k == ab) vcc_ok = 1'b1;
         if (mode == 3 && k == kev) vcc_ok = 1'b0;
         if (mode == 3 && k == kev + 1) vcc_ok = 1'b1;
         if (mode == 2 && k == kev) begin
            ctrl_wr = 1'b1;
            ctrl_wdata = 2'b00;
            pend = 1;
         end
         if (mode == 4 && k == kev) vdd_ok = 1'b0;
      end
      if (ab < 0) begin
         host_write(2'b00);
         chk("R11 stop after reset release", pins(), 5'b00001);
         chk("R11 no fault on stop", status[3], 1'b0);
         chk("R10 status up cleared", status[2], 1'b0);
      end else if (mode == 4) begin
         power_up();
      end else begin
         host_write(2'b00);
         chk("R9 fault sticky", status[3], 1'b1);
         host_write(2'b10);
         chk("R9 fault cleared", status[3], 1'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      int mode;
      seed = $urandom(32'h5eed);
      repeat (3) tick();
      chk("R1 pins in reset", pins(), 5'b00000);
      chk("R1 fault in reset", status[3], 1'b0);
      rst_n = 1'b1;
      for (int n = 0; n < 5; n++) begin
         tick();
         chk("R1 irq low without vdd", irq_line, 1'b0);
      end
      host_write(2'b01);
      chk("R3 start in idle ignored", vcc_en, 1'b0);
      power_up();

      for (int n = 0; n < 4; n++) begin
         card_present = 1'($urandom_range(0, 1));
         vcc_ok = 1'($urandom_range(0, 1));
         tick();
         chk("R10 status present", status[0], card_present);
         chk("R10 status supply", status[1], vcc_ok);
      end
      vcc_ok = 1'b1;
      card_present = 1'b0;
      host_write(2'b01);
      for (int n = 0; n < 3; n++) begin
         chk("R3 start without card ignored", pins(), 5'b00001);
         tick();
      end
      card_present = 1'b1;

      run_seq(0, 0);
      run_seq(1, T1 - 1);
      run_seq(3, T1 - 2);
      run_seq(2, KR - 2);
      run_seq(2, 1);
      run_seq(4, KR + 3);

      for (int it = 0; it < 6; it++) begin
         mode = $urandom_range(0, 4);
         case (mode)
            1: run_seq(1, $urandom_range(1, T1 - 1));
            2: run_seq(2, $urandom_range(1, KR - 2));
            3: run_seq(3, $urandom_range(1, T1 - 2));
            4: run_seq(4, $urandom_range(1, KR + 3));
            default: run_seq(0, 0);
         endcase
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule